// File: doc/BRIEF.md
# I2C Random-Read Transaction Sequencer

This block drives a status-coded I2C master controller through its byte-wide register interface. It performs one complete register-offset read from a slave device without software involvement. A single `start` pulse latches a 7-bit device address, an 8- or 16-bit offset and a byte count. The sequencer then:

- re-initialises the controller and enables it;
- addresses the slave for writing and sends the offset;
- turns the bus around with a repeated START;
- reads the requested bytes, then releases the bus with STOP.

Each step consists of a control write, optionally preceded by a data-register write. After the control write the sequencer polls the controller's status register until that step's one expected code appears. Polls are spaced by a programmable number of clock cycles, and the number of polls per step is bounded. Received bytes stream out on `rx_data` with a one-cycle `rx_valid` strobe. The run ends with a `done` pulse carrying the number of bytes delivered. If a step's status never arrives, the run instead ends with an `error` pulse carrying the last status seen.

The register offsets are fixed by the controller's decoder: 0x00 own slave address, 0x04 data, 0x08 control, 0x0C status on read and baud on write, 0x10 extended slave address, 0x1C soft reset. Bus reads return data in `bus_rdata` on the cycle after `bus_re`.

Top module: `i2crr_top`

## Requirements
- R1: After reset `bus_we`, `bus_re`, `rx_valid`, `done` and `error` are low, and no bus access occurs until `start`. `bus_we` and `bus_re` are never high in the same cycle.
- R2: The run begins with these writes, in order: soft reset (0x1C ← 0x00), own slave address (0x00 ← 0x00), extended slave address (0x10 ← 0x00) and baud (0x0C ← 0x24). It then writes control 0x40 (enable only) and expects status 0xF8. Control bits are: enable 0x40, START 0x20, STOP 0x10, ACK 0x04.
- R3: Next come control 0x60 (expect 0x08), then data `{dev_addr,0}` and control 0x40 (expect 0x18). The offset bytes follow, each as a data write plus control 0x40 expecting 0x28. When `off_two`=1 the high byte `offset[15:8]` goes first and the low byte second; when `off_two`=0 only `offset[7:0]` is sent.
- R4: After the offset come control 0x60 for a repeated START (expect 0x10), then data `{dev_addr,1}` and control 0x40 (expect 0x40).
- R5: For an effective count N (a `count` of 0 counts as 1), the first N-1 bytes are each requested with control 0x44 (expect 0x50). The last byte is requested with control 0x40 (expect 0x58). N=1 goes straight to the last-byte request.
- R6: The data register (0x04) is read only after a matching 0x50/0x58 status. Each byte read appears on `rx_data` with one `rx_valid` pulse, two cycles after the read, in order.
- R7: After the last byte the sequencer writes control 0x50 and expects 0xF8. On a match it pulses `done`, sets `done_count` to N, and returns to idle. `done` and `error` never pulse together.
- R8: Each status read (0x0C) comes at least `POLL_CYC` cycles after the step's control write or the previous status read. At most `MAX_POLLS` status reads are made per step, and a match on the last allowed read still continues the run.
- R9: If `MAX_POLLS` reads all mismatch, the sequencer:
  - pulses `error` with `err_status` set to the last status read;
  - makes no further bus access (no STOP);
  - returns to idle, where a new `start` is accepted.
- R10: A `start` pulse while a run is in progress is ignored, and the run's bus writes keep the values latched at its own start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (ignored while busy) |
| dev_addr | input | 7 | Slave device address |
| offset | input | 16 | Register offset inside the slave |
| off_two | input | 1 | 1: two offset bytes, 0: one |
| count | input | CNT_W | Bytes to read (0 counts as 1) |
| bus_we | output | 1 | Controller register write strobe |
| bus_re | output | 1 | Controller register read strobe |
| bus_addr | output | 5 | Controller register offset |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid the cycle after `bus_re` |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| done | output | 1 | Run finished successfully (pulse) |
| done_count | output | CNT_W | Bytes delivered by the last successful run |
| error | output | 1 | Run aborted on status timeout (pulse) |
| err_status | output | 8 | Last status read before the abort |

## Verification
The read sequence is swept over both offset widths and every count from 0 to 6. This separates the one-byte and two-byte offset paths, the direct last-byte path for N=1 (and for 0), and the ACK-read loop for longer runs. The controller model delays each status by a varying number of polls, including the exact poll limit, to separate "arrives in time" from "arrives one poll too late". A stuck mismatching status is then injected at every step in turn. This shows the abort point, the reported status and the absence of STOP for each position in the sequence. A stray `start` is pulsed mid-run in every transaction to show that the latched parameters stay in force.

// File: rtl/i2crr_pkg.sv
package i2crr_pkg;

  // Controller register offsets (decoded by the controller)
  localparam logic [4:0] RA_OWN   = 5'h00;
  localparam logic [4:0] RA_DATA  = 5'h04;
  localparam logic [4:0] RA_CTRL  = 5'h08;
  localparam logic [4:0] RA_STAT  = 5'h0C;  // status on read, baud on write
  localparam logic [4:0] RA_XOWN  = 5'h10;
  localparam logic [4:0] RA_SRST  = 5'h1C;

  // Control bits
  localparam logic [7:0] CB_ACK   = 8'h04;
  localparam logic [7:0] CB_STOP  = 8'h10;
  localparam logic [7:0] CB_START = 8'h20;
  localparam logic [7:0] CB_EN    = 8'h40;

  // Status codes
  localparam logic [7:0] SC_IDLE   = 8'hF8;
  localparam logic [7:0] SC_START  = 8'h08;
  localparam logic [7:0] SC_RSTART = 8'h10;
  localparam logic [7:0] SC_AW_ACK = 8'h18;
  localparam logic [7:0] SC_WD_ACK = 8'h28;
  localparam logic [7:0] SC_AR_ACK = 8'h40;
  localparam logic [7:0] SC_RD_ACK = 8'h50;
  localparam logic [7:0] SC_RD_NAK = 8'h58;

  localparam logic [7:0] BAUD_INIT = (8'd4 << 3) | 8'd4;

  typedef enum logic [3:0] {
    PH_EN, PH_START, PH_ADDRW, PH_OFFH, PH_OFFL,
    PH_RSTART, PH_ADDRR, PH_RDACK, PH_RDNAK, PH_STOP
  } phase_t;

  typedef struct packed {
    logic [7:0] ctrl;   // control byte to write
    logic [7:0] want;   // the one status accepted
    logic       sends;  // a data write precedes the control write
    logic       fetch;  // a data read follows the matching status
  } step_t;

  function automatic step_t step_of(phase_t ph);
    step_t s;
    s = '{ctrl: CB_EN, want: SC_IDLE, sends: 1'b0, fetch: 1'b0};
    case (ph)
      PH_EN:     s = '{ctrl: CB_EN,            want: SC_IDLE,   sends: 1'b0, fetch: 1'b0};
      PH_START:  s = '{ctrl: CB_EN | CB_START, want: SC_START,  sends: 1'b0, fetch: 1'b0};
      PH_ADDRW:  s = '{ctrl: CB_EN,            want: SC_AW_ACK, sends: 1'b1, fetch: 1'b0};
      PH_OFFH:   s = '{ctrl: CB_EN,            want: SC_WD_ACK, sends: 1'b1, fetch: 1'b0};
      PH_OFFL:   s = '{ctrl: CB_EN,            want: SC_WD_ACK, sends: 1'b1, fetch: 1'b0};
      PH_RSTART: s = '{ctrl: CB_EN | CB_START, want: SC_RSTART, sends: 1'b0, fetch: 1'b0};
      PH_ADDRR:  s = '{ctrl: CB_EN,            want: SC_AR_ACK, sends: 1'b1, fetch: 1'b0};
      PH_RDACK:  s = '{ctrl: CB_EN | CB_ACK,   want: SC_RD_ACK, sends: 1'b0, fetch: 1'b1};
      PH_RDNAK:  s = '{ctrl: CB_EN,            want: SC_RD_NAK, sends: 1'b0, fetch: 1'b1};
      PH_STOP:   s = '{ctrl: CB_EN | CB_STOP,  want: SC_IDLE,   sends: 1'b0, fetch: 1'b0};
      default:   s = '{ctrl: CB_EN,            want: SC_IDLE,   sends: 1'b0, fetch: 1'b0};
    endcase
    return s;
  endfunction

  // Phase order; 'last' means exactly one byte remains to be read
  function automatic phase_t phase_after(phase_t ph, logic two, logic last);
    case (ph)
      PH_EN:     return PH_START;
      PH_START:  return PH_ADDRW;
      PH_ADDRW:  return two ? PH_OFFH : PH_OFFL;
      PH_OFFH:   return PH_OFFL;
      PH_OFFL:   return PH_RSTART;
      PH_RSTART: return PH_ADDRR;
      PH_ADDRR:  return last ? PH_RDNAK : PH_RDACK;
      PH_RDACK:  return last ? PH_RDNAK : PH_RDACK;
      default:   return PH_STOP;
    endcase
  endfunction

  function automatic logic [7:0] tx_byte(phase_t ph, logic [6:0] dev, logic [15:0] off);
    case (ph)
      PH_ADDRW: return {dev, 1'b0};
      PH_OFFH:  return off[15:8];
      PH_OFFL:  return off[7:0];
      PH_ADDRR: return {dev, 1'b1};
      default:  return 8'h00;
    endcase
  endfunction

  function automatic logic [4:0] init_reg(logic [1:0] i);
    case (i)
      2'd0:    return RA_SRST;
      2'd1:    return RA_OWN;
      2'd2:    return RA_XOWN;
      default: return RA_STAT;
    endcase
  endfunction

  function automatic logic [7:0] init_val(logic [1:0] i);
    return (i == 2'd3) ? BAUD_INIT : 8'h00;
  endfunction

endpackage

// File: rtl/i2crr_poll.sv
module i2crr_poll #(
  parameter int POLL_CYC  = 2500,
  parameter int MAX_POLLS = 1000,
  localparam int IW = (POLL_CYC  > 1) ? $clog2(POLL_CYC)      : 1,
  localparam int TW = $clog2(MAX_POLLS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,       // new step: restart interval and attempt count
  input  logic          wait_en,   // interval is running
  output logic          due,       // interval elapsed: a status read may go out
  output logic [TW-1:0] tries,     // status reads made in this step
  output logic          exhausted  // no reads left in this step
);

  logic [IW-1:0] ivl_q;

  assign due       = wait_en && (ivl_q == IW'(POLL_CYC - 1));
  assign exhausted = (tries >= TW'(MAX_POLLS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ivl_q <= '0;
      tries <= '0;
    end else if (arm) begin
      ivl_q <= '0;
      tries <= '0;
    end else if (wait_en) begin
      if (due) begin
        ivl_q <= '0;
        tries <= tries + 1'b1;
      end else begin
        ivl_q <= ivl_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/i2crr_fsm.sv
module i2crr_fsm
  import i2crr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [6:0]       dev_addr,
  input  logic [15:0]      offset,
  input  logic             off_two,
  input  logic [CNT_W-1:0] count,
  input  logic             poll_due,
  input  logic             poll_exhausted,
  output logic             poll_arm,
  output logic             poll_wait,
  output logic             bus_we,
  output logic             bus_re,
  output logic [4:0]       bus_addr,
  output logic [7:0]       bus_wdata,
  input  logic [7:0]       bus_rdata,
  output logic             stat_hit,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  output logic             done,
  output logic [CNT_W-1:0] done_count,
  output logic             error,
  output logic [7:0]       err_status
);

  typedef enum logic [3:0] {
    S_IDLE, S_INIT, S_DWR, S_CWR, S_WAIT, S_SRD, S_SCHK, S_DRD, S_DCAP
  } st_t;

  st_t              st_q;
  phase_t           ph_q;
  logic [1:0]       idx_q;
  logic [6:0]       dev_q;
  logic [15:0]      off_q;
  logic             two_q;
  logic [CNT_W-1:0] rem_q;
  logic [CNT_W-1:0] tot_q;

  step_t            cur;
  step_t            nx_step;
  phase_t           ph_nx;
  logic [CNT_W-1:0] rem_after;
  logic             advance;

  assign cur       = step_of(ph_q);
  assign rem_after = (st_q == S_DCAP) ? rem_q - 1'b1 : rem_q;
  assign ph_nx     = phase_after(ph_q, two_q, rem_after == CNT_W'(1));
  assign nx_step   = step_of(ph_nx);
  assign stat_hit  = (st_q == S_SCHK) && (bus_rdata == cur.want);
  assign advance   = (stat_hit && !cur.fetch) || (st_q == S_DCAP);
  assign poll_arm  = (st_q == S_CWR);
  assign poll_wait = (st_q == S_WAIT);

  always_comb begin
    bus_we    = 1'b0;
    bus_re    = 1'b0;
    bus_addr  = RA_OWN;
    bus_wdata = 8'h00;
    case (st_q)
      S_INIT: begin bus_we = 1'b1; bus_addr = init_reg(idx_q); bus_wdata = init_val(idx_q); end
      S_DWR:  begin bus_we = 1'b1; bus_addr = RA_DATA; bus_wdata = tx_byte(ph_q, dev_q, off_q); end
      S_CWR:  begin bus_we = 1'b1; bus_addr = RA_CTRL; bus_wdata = cur.ctrl; end
      S_SRD:  begin bus_re = 1'b1; bus_addr = RA_STAT; end
      S_DRD:  begin bus_re = 1'b1; bus_addr = RA_DATA; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      ph_q       <= PH_EN;
      idx_q      <= '0;
      dev_q      <= '0;
      off_q      <= '0;
      two_q      <= 1'b0;
      rem_q      <= '0;
      tot_q      <= '0;
      rx_data    <= '0;
      rx_valid   <= 1'b0;
      done       <= 1'b0;
      done_count <= '0;
      error      <= 1'b0;
      err_status <= '0;
    end else begin
      done     <= 1'b0;
      error    <= 1'b0;
      rx_valid <= 1'b0;
      case (st_q)
        S_IDLE: if (start) begin
          dev_q <= dev_addr;
          off_q <= offset;
          two_q <= off_two;
          rem_q <= (count == '0) ? CNT_W'(1) : count;
          tot_q <= (count == '0) ? CNT_W'(1) : count;
          idx_q <= '0;
          st_q  <= S_INIT;
        end
        S_INIT: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == 2'd3) begin
            ph_q <= PH_EN;
            st_q <= S_CWR;
          end
        end
        S_DWR:  st_q <= S_CWR;
        S_CWR:  st_q <= S_WAIT;
        S_WAIT: if (poll_due) st_q <= S_SRD;
        S_SRD:  st_q <= S_SCHK;
        S_SCHK: begin
          if (stat_hit) begin
            if (cur.fetch) st_q <= S_DRD;
          end else if (poll_exhausted) begin
            error      <= 1'b1;
            err_status <= bus_rdata;
            st_q       <= S_IDLE;
          end else begin
            st_q <= S_WAIT;
          end
        end
        S_DRD:  st_q <= S_DCAP;
        S_DCAP: begin
          rx_data  <= bus_rdata;
          rx_valid <= 1'b1;
          rem_q    <= rem_after;
        end
        default: st_q <= S_IDLE;
      endcase
      if (advance) begin
        if (ph_q == PH_STOP) begin
          done       <= 1'b1;
          done_count <= tot_q;
          st_q       <= S_IDLE;
        end else begin
          ph_q <= ph_nx;
          st_q <= nx_step.sends ? S_DWR : S_CWR;
        end
      end
    end
  end

endmodule

// File: rtl/i2crr_top.sv
module i2crr_top
  import i2crr_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int POLL_CYC  = 2500,
  parameter int MAX_POLLS = 1000,
  localparam int TW = $clog2(MAX_POLLS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [6:0]       dev_addr,
  input  logic [15:0]      offset,
  input  logic             off_two,
  input  logic [CNT_W-1:0] count,
  output logic             bus_we,
  output logic             bus_re,
  output logic [4:0]       bus_addr,
  output logic [7:0]       bus_wdata,
  input  logic [7:0]       bus_rdata,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  output logic             done,
  output logic [CNT_W-1:0] done_count,
  output logic             error,
  output logic [7:0]       err_status
);

  // Internal events, named for the checker
  logic          poll_due;
  logic          poll_exhausted;
  logic          poll_arm;
  logic          poll_wait;
  logic [TW-1:0] poll_tries;
  logic          stat_hit;
  logic          data_rd;

  assign data_rd = bus_re && (bus_addr == RA_DATA);

  i2crr_poll #(.POLL_CYC(POLL_CYC), .MAX_POLLS(MAX_POLLS)) u_poll (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (poll_arm),
    .wait_en   (poll_wait),
    .due       (poll_due),
    .tries     (poll_tries),
    .exhausted (poll_exhausted)
  );

  i2crr_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .start          (start),
    .dev_addr       (dev_addr),
    .offset         (offset),
    .off_two        (off_two),
    .count          (count),
    .poll_due       (poll_due),
    .poll_exhausted (poll_exhausted),
    .poll_arm       (poll_arm),
    .poll_wait      (poll_wait),
    .bus_we         (bus_we),
    .bus_re         (bus_re),
    .bus_addr       (bus_addr),
    .bus_wdata      (bus_wdata),
    .bus_rdata      (bus_rdata),
    .stat_hit       (stat_hit),
    .rx_data        (rx_data),
    .rx_valid       (rx_valid),
    .done           (done),
    .done_count     (done_count),
    .error          (error),
    .err_status     (err_status)
  );

endmodule

// File: rtl/i2crr_chk.sv
module i2crr_chk #(
  parameter int MAX_POLLS = 1000,
  localparam int TW = $clog2(MAX_POLLS + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_we,
  input logic          bus_re,
  input logic [4:0]    bus_addr,
  input logic          rx_valid,
  input logic          done,
  input logic          error,
  input logic          poll_due,
  input logic          stat_hit,
  input logic          data_rd,
  input logic [TW-1:0] poll_tries
);

  p_single_access_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_re));

  p_fetch_after_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd |-> $past(stat_hit));

  p_byte_after_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(data_rd, 2));

  p_end_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));

  p_read_on_due_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_addr == 5'h0C) |-> $past(poll_due));

  p_tries_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    poll_tries <= TW'(MAX_POLLS));

  p_quiet_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> !bus_we && !bus_re);

  p_no_stop_after_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> !bus_we);

endmodule

bind i2crr_top i2crr_chk #(.MAX_POLLS(MAX_POLLS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_we     (bus_we),
  .bus_re     (bus_re),
  .bus_addr   (bus_addr),
  .rx_valid   (rx_valid),
  .done       (done),
  .error      (error),
  .poll_due   (poll_due),
  .stat_hit   (stat_hit),
  .data_rd    (data_rd),
  .poll_tries (poll_tries)
);

// File: tb/sim_i2crr_top.sv
module sim_i2crr_top;

  localparam int CNT_W = 8;
  localparam int P     = 4;
  localparam int MAXP  = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [6:0]       dev_addr = '0;
  logic [15:0]      offset = '0;
  logic             off_two = 1'b0;
  logic [CNT_W-1:0] count = '0;
  logic             bus_we, bus_re;
  logic [4:0]       bus_addr;
  logic [7:0]       bus_wdata;
  logic [7:0]       bus_rdata = 8'h00;
  logic [7:0]       rx_data;
  logic             rx_valid, done, error;
  logic [CNT_W-1:0] done_count;
  logic [7:0]       err_status;

  always #2 clk = ~clk;  // 250 MHz

  i2crr_top #(.CNT_W(CNT_W), .POLL_CYC(P), .MAX_POLLS(MAXP)) u0 (.*);

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // ---------------- controller model ----------------
  int       cyc = 0, last_ref = 0, gap_bad = 0;
  int       wn = 0, cw = 0, sreads = 0, rxi = 0, gn = 0;
  int       resp_n = 1, fail_at = 0;
  bit       act = 0, stuck = 0;
  logic [7:0] fin = 8'hF8, prev = 8'hF8, dreg = 8'h00, salt = 8'h00;
  logic [4:0] wa [64];
  logic [7:0] wd [64];
  logic [7:0] got [64];

  function automatic logic [7:0] pat(logic [7:0] s, int i);
    return (8'h3C + 8'(i * 29)) ^ s;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (bus_we) begin
      if (wn < 64) begin wa[wn] = bus_addr; wd[wn] = bus_wdata; end
      wn++;
      if (bus_addr == 5'h04) dreg = bus_wdata;
      if (bus_addr == 5'h08) begin
        cw++; sreads = 0; last_ref = cyc;
        if (bus_wdata & 8'h10) begin fin = 8'hF8; act = 0; end
        else if (bus_wdata & 8'h20) begin fin = act ? 8'h10 : 8'h08; act = 1; end
        else if (!act) fin = 8'hF8;
        else if (prev == 8'h08 || prev == 8'h10) fin = dreg[0] ? 8'h40 : 8'h18;
        else if (prev == 8'h18 || prev == 8'h28) fin = 8'h28;
        else if (prev == 8'h40 || prev == 8'h50) begin
          fin = (bus_wdata & 8'h04) ? 8'h50 : 8'h58;
          dreg = pat(salt, rxi); rxi++;
        end else fin = 8'hF8;
        prev = fin;
        stuck = (cw == fail_at);
      end
    end
    if (bus_re) begin
      if (bus_addr == 5'h0C) begin
        if (cyc - last_ref < P) gap_bad++;
        last_ref = cyc; sreads++;
        bus_rdata <= stuck ? 8'h38 : ((sreads >= resp_n) ? fin : 8'hFF);
      end else if (bus_addr == 5'h04) bus_rdata <= dreg;
    end
    if (rx_valid) begin
      if (gn < 64) got[gn] = rx_data;
      gn++;
    end
  end

  // ---------------- expected bus write list ----------------
  logic [4:0] e_a [64];
  logic [7:0] e_d [64];
  int e_n;

  task automatic push(input logic [4:0] a, input logic [7:0] d);
    e_a[e_n] = a; e_d[e_n] = d; e_n++;
  endtask

  task automatic build(input logic [6:0] dv, input logic [15:0] of, input bit two, input int n);
    e_n = 0;
    push(5'h1C, 8'h00); push(5'h00, 8'h00); push(5'h10, 8'h00); push(5'h0C, 8'h24);
    push(5'h08, 8'h40); push(5'h08, 8'h60); push(5'h04, {dv, 1'b0}); push(5'h08, 8'h40);
    if (two) begin push(5'h04, of[15:8]); push(5'h08, 8'h40); end
    push(5'h04, of[7:0]); push(5'h08, 8'h40);
    push(5'h08, 8'h60); push(5'h04, {dv, 1'b1}); push(5'h08, 8'h40);
    for (int i = 0; i < n - 1; i++) push(5'h08, 8'h44);
    push(5'h08, 8'h40); push(5'h08, 8'h50);
  endtask

  function automatic int mism(input int lo, input int hi);
    int m = 0;
    for (int i = lo; i < hi; i++)
      if (i >= 64 || wa[i] !== e_a[i] || wd[i] !== e_d[i]) m++;
    return m;
  endfunction

  int tx_no = 0;

  task automatic run(input logic [6:0] dv, input logic [15:0] of, input bit two,
                     input int cnt, input int rn, input int fa);
    int k, n, cut, seen, wn_end;
    bit exp_err;
    tx_no++;
    wn = 0; cw = 0; rxi = 0; gn = 0; act = 0; prev = 8'hF8; stuck = 0;
    resp_n = rn; fail_at = fa; salt = 8'(tx_no * 17); gap_bad = 0;
    @(negedge clk);
    dev_addr = dv; offset = of; off_two = two; count = CNT_W'(cnt); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 0;
    while (!(done || error) && k < 20000) begin
      @(negedge clk); k++;
      if (k == 12) begin start = 1'b1; dev_addr = ~dv; offset = ~of; off_two = ~two; end
      else start = 1'b0;
    end
    start = 1'b0;
    n = (cnt == 0) ? 1 : cnt;
    build(dv, of, two, n);
    exp_err = (fa != 0) || (rn > MAXP);
    if (!exp_err) begin
      chk(done === 1'b1, "R7 done pulse", done, 1);
      chk(done_count == CNT_W'(n), "R7 done_count", done_count, n);
      chk(wn == e_n, "R3/R10 write count", wn, e_n);
      chk(mism(0, 5) == 0, "R2 init writes", mism(0, 5), 0);
      chk(mism(5, e_n - n - 1) == 0, "R3/R4/R10 address and offset writes", mism(5, e_n - n - 1), 0);
      chk(mism(e_n - n - 1, e_n - 1) == 0, "R5 read controls", mism(e_n - n - 1, e_n - 1), 0);
      chk(wa[e_n-1] == 5'h08 && wd[e_n-1] == 8'h50, "R7 stop control", wd[e_n-1], 8'h50);
      chk(gn == n, "R6 byte count", gn, n);
      begin
        int bm = 0;
        for (int i = 0; i < n && i < 64; i++) if (got[i] !== pat(salt, i)) bm++;
        chk(bm == 0, "R6 byte values", bm, 0);
      end
      chk(gap_bad == 0, "R8 poll spacing", gap_bad, 0);
    end else begin
      seen = 0; cut = 0;
      for (int i = 0; i < e_n; i++)
        if (e_a[i] == 5'h08) begin
          seen++;
          if (seen == ((fa != 0) ? fa : 1)) begin cut = i; break; end
        end
      chk(error === 1'b1, "R9 error pulse", error, 1);
      chk(err_status == ((fa != 0) ? 8'h38 : 8'hFF), "R9 err_status", err_status,
          (fa != 0) ? 8'h38 : 8'hFF);
      chk(wn == cut + 1, "R9 writes stop at failing step", wn, cut + 1);
      chk(mism(0, cut + 1) == 0, "R9 prefix writes", mism(0, cut + 1), 0);
      chk(sreads == MAXP, "R8 poll limit", sreads, MAXP);
      wn_end = wn;
      repeat (4 * P) @(negedge clk);
      chk(wn == wn_end && !bus_re, "R9 idle after abort", wn, wn_end);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0x%0h expected=0x%0h", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!bus_we && !bus_re && !rx_valid && !done && !error, "R1 reset outputs",
        {bus_we, bus_re, rx_valid, done, error}, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(wn == 0 && !bus_re, "R1 no access before start", wn, 0);
    // main sweep: both offset widths, counts 0..6, varied status delay
    for (int two = 0; two < 2; two++)
      for (int c = 0; c <= 6; c++)
        run(7'(7'h50 + c), 16'(16'hA5C3 + c * 16'h0101), two[0], c, (c % 3) + 1, 0);
    // status arrives on the last allowed poll
    run(7'h2A, 16'h1234, 1'b1, 3, MAXP, 0);
    // stuck mismatch injected at every step of the sequence
    for (int f = 1; f <= 10; f++) run(7'h33, 16'hBEEF, 1'b1, 2, 2, f);
    // status one poll too late
    run(7'h11, 16'h0042, 1'b0, 1, MAXP + 1, 0);
    // recovery after abort
    run(7'h7F, 16'hFFFF, 1'b0, 4, 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule